// File: doc/BRIEF.md
# Configurable Packet Transmit Framer

This block turns a stream of payload bytes into a framed over-the-air bit stream. Each packet opens with an alternating preamble, then one to four sync bytes and zero to four header bytes. An optional length byte follows, then the payload taken from an upstream byte source, and an optional 16-bit CRC at the end. Every field's presence, the sync and header counts, what the CRC covers and the bit order are chosen at run time through configuration inputs. The framer is therefore a run-time-shaped packet builder rather than a fixed serializer.

The serial side is paced by an external bit strobe: the current bit stays on the output until a strobe cycle consumes it. A one-cycle pulse marks the end of each packet. When packet handling is switched off, only the payload bytes go out, with no preamble, sync, header, length or CRC.

Top module: `pkt_tx_framer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ser_active`, `in_ready` and `pkt_sent` are low.
- R2: With framing on, the preamble is `{cfg_pre_msb, cfg_pre_len}` nibbles long. Each nibble is the bits 1,0,1,0. A value of zero gives no preamble. The preamble is never bit-reversed.
- R3: Sync code 0..3 sends 1..4 sync bytes. They are taken from `cfg_sync_word` starting at bits [31:24] and moving down one byte each time.
- R4: Header code 0..4 sends that many header bytes from `cfg_hdr_word`, starting at bits [31:24] and moving down. Codes 5..7 act as 4.
- R5: When `cfg_fix_len` is clear, a length byte equal to `cfg_pay_len` follows the header. When it is set, no length byte is sent.
- R6: A packet starts only when the block is idle, `in_valid` is high and `cfg_pay_len` is nonzero. Exactly `cfg_pay_len` payload bytes are taken, each on a cycle with `in_ready` and `in_valid` both high. `in_ready` is never high without `in_valid`.
- R7: With framing and CRC on, two CRC bytes follow the payload, high byte first. The CRC uses polynomial 0x1021 and start value 0xFFFF, and each byte value is fed MSB first. It covers header, length and payload bytes, or only the payload when `cfg_crc_data_only` is set.
- R8: With `cfg_lsb_first` clear, every non-preamble byte is sent MSB first. With it set, every such byte, including CRC and unframed bytes, is sent LSB first.
- R9: With `cfg_pkt_en` low, the bit stream is only the payload bytes, with no other field.
- R10: `ser_bit` is meaningful while `ser_active` is high. It is held until a cycle where `bit_stb` is high, and that cycle consumes it.
- R11: `pkt_sent` is high for exactly one cycle, the cycle after the strobe that consumes the last bit of the packet.
- R12: Configuration is captured when a packet starts. Changes during the packet do not affect that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pkt_en | input | 1 | Framing enable; low sends raw payload |
| cfg_pre_len | input | 8 | Preamble length in nibbles, low bits |
| cfg_pre_msb | input | 1 | Preamble length, ninth bit |
| cfg_sync_cnt | input | 2 | Sync byte count minus one |
| cfg_hdr_cnt | input | 3 | Header byte count (clamped to 4) |
| cfg_fix_len | input | 1 | Omit length byte |
| cfg_crc_en | input | 1 | Append CRC |
| cfg_crc_data_only | input | 1 | CRC covers payload only |
| cfg_lsb_first | input | 1 | Send bytes LSB first |
| cfg_sync_word | input | 32 | Sync bytes, first sent in [31:24] |
| cfg_hdr_word | input | 32 | Header bytes, first sent in [31:24] |
| cfg_pay_len | input | 8 | Payload byte count |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle |
| bit_stb | input | 1 | Bit strobe: consume current bit |
| ser_bit | output | 1 | Serial output bit |
| ser_active | output | 1 | A bit is present on `ser_bit` |
| pkt_sent | output | 1 | One-cycle end-of-packet pulse |

## Verification
Two events can land on the same edge. One is the strobe that consumes the last bit of a byte. The other is the load of the next byte, which for payload also means the handshake that takes it from the input. The bench provokes this with runs where the strobe and `in_valid` are high every cycle, so each byte boundary is a consume-and-refill edge. Other runs leave random gaps in both, so refills also happen after the output has gone idle. The result is judged by comparing the collected bit stream against a model built from the configuration: a dropped or doubled bit at any boundary shows up as a length or content mismatch. Pulse timing and the byte count taken are checked as well.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

    localparam int BYTE_W    = 8;
    localparam int PRE_W     = 8;
    localparam int PRE_NIB_W = PRE_W + 1;
    localparam int LEN_W     = 8;
    localparam int MAX_WORDS = 4;
    localparam int WORD_W    = BYTE_W * MAX_WORDS;
    localparam int SEL_W     = $clog2(MAX_WORDS);
    localparam int HCNT_W    = 3;
    localparam int BITCNT_W  = $clog2(BYTE_W + 1);
    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0]  CRC_POLY    = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_INIT    = 16'hFFFF;
    localparam logic [BYTE_W-1:0] PRE_FULL    = 8'hAA;
    localparam logic [BYTE_W-1:0] PRE_HALF    = 8'hA0;

    typedef enum logic [3:0] {
        F_IDLE, F_PRE, F_SYNC, F_HDR, F_LEN, F_PAY, F_CRCH, F_CRCL, F_DONE
    } field_e;

    typedef struct packed {
        logic                  pkt_en;
        logic [PRE_NIB_W-1:0]  pre_nib;
        logic [SEL_W-1:0]      sync_last;
        logic [HCNT_W-1:0]     hdr_num;
        logic                  fix_len;
        logic                  crc_en;
        logic                  crc_data_only;
        logic                  lsb_first;
        logic [WORD_W-1:0]     sync_w;
        logic [WORD_W-1:0]     hdr_w;
        logic [LEN_W-1:0]      pay_len;
    } cfg_t;

    function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = BYTE_W-1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else                   r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w,
                                                    input logic [SEL_W-1:0] sel);
        return w[WORD_W-1 - int'(sel)*BYTE_W -: BYTE_W];
    endfunction

    function automatic logic [HCNT_W-1:0] clamp_hdr(input logic [HCNT_W-1:0] code);
        return (code > HCNT_W'(MAX_WORDS)) ? HCNT_W'(MAX_WORDS) : code;
    endfunction

endpackage

// File: rtl/ptf_crc16.sv
module ptf_crc16
    import ptf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              upd,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_INIT;
        else if (upd)    crc_q <= crc_step(crc_q, byte_in);
    end

    assign crc_out = crc_q;

endmodule

// File: rtl/ptf_shifter.sv
module ptf_shifter
    import ptf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [BYTE_W-1:0]   ld_data,
    input  logic [BITCNT_W-1:0] ld_bits,
    input  logic                bit_stb,
    output logic                ser_bit,
    output logic                ser_active,
    output logic                can_load,
    output logic                drain_done
);

    logic [BYTE_W-1:0]   sh_q;
    logic [BITCNT_W-1:0] cnt_q;
    logic                full_q;
    logic                consume;
    logic                last_bit;

    assign consume    = full_q && bit_stb;
    assign last_bit   = (cnt_q == BITCNT_W'(1));
    assign drain_done = consume && last_bit;
    assign can_load   = !full_q || drain_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (take) begin
            sh_q   <= ld_data;
            cnt_q  <= ld_bits;
            full_q <= 1'b1;
        end else if (consume) begin
            if (last_bit) begin
                full_q <= 1'b0;
            end else begin
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                cnt_q <= cnt_q - BITCNT_W'(1);
            end
        end
    end

    assign ser_bit    = sh_q[BYTE_W-1];
    assign ser_active = full_q;

endmodule

// File: rtl/ptf_sequencer.sv
module ptf_sequencer
    import ptf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cfg_t                cfg_in,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                can_load,
    input  logic                drain_done,
    input  logic [CRC_W-1:0]    crc_val,
    output logic                take,
    output logic [BYTE_W-1:0]   nxt_data,
    output logic [BITCNT_W-1:0] nxt_bits,
    output logic                in_ready,
    output logic                crc_init,
    output logic                crc_upd,
    output logic [BYTE_W-1:0]   crc_byte,
    output logic                pkt_sent
);

    field_e               st_q;
    cfg_t                 cfg_q;
    logic [PRE_NIB_W-1:0] pre_left_q;
    logic [SEL_W-1:0]     idx_q;
    logic [LEN_W-1:0]     pay_cnt_q;
    logic                 sent_q;

    logic                 nxt_vld;
    logic [BYTE_W-1:0]    raw_byte;
    logic                 start;
    field_e               after_hdr, after_sync, after_pay;

    assign start = (st_q == F_IDLE) && in_valid && (cfg_in.pay_len != '0);

    always_comb begin
        after_hdr  = cfg_q.fix_len ? F_PAY : F_LEN;
        after_sync = (cfg_q.hdr_num != '0) ? F_HDR : after_hdr;
        after_pay  = (cfg_q.pkt_en && cfg_q.crc_en) ? F_CRCH : F_DONE;
    end

    always_comb begin
        nxt_vld  = 1'b0;
        raw_byte = '0;
        nxt_bits = BITCNT_W'(BYTE_W);
        unique case (st_q)
            F_PRE: begin
                nxt_vld = 1'b1;
                if (pre_left_q >= PRE_NIB_W'(2)) begin
                    raw_byte = PRE_FULL;
                end else begin
                    raw_byte = PRE_HALF;
                    nxt_bits = BITCNT_W'(BYTE_W/2);
                end
            end
            F_SYNC: begin nxt_vld = 1'b1;     raw_byte = word_byte(cfg_q.sync_w, idx_q); end
            F_HDR:  begin nxt_vld = 1'b1;     raw_byte = word_byte(cfg_q.hdr_w, idx_q);  end
            F_LEN:  begin nxt_vld = 1'b1;     raw_byte = cfg_q.pay_len;                  end
            F_PAY:  begin nxt_vld = in_valid; raw_byte = in_data;                        end
            F_CRCH: begin nxt_vld = 1'b1;     raw_byte = crc_val[CRC_W-1 -: BYTE_W];     end
            F_CRCL: begin nxt_vld = 1'b1;     raw_byte = crc_val[BYTE_W-1:0];            end
            default: begin nxt_vld = 1'b0; end
        endcase
    end

    assign nxt_data = (st_q != F_PRE && cfg_q.lsb_first) ? bit_rev(raw_byte) : raw_byte;
    assign take     = nxt_vld && can_load;
    assign in_ready = take && (st_q == F_PAY);
    assign crc_init = start;
    assign crc_byte = raw_byte;
    assign crc_upd  = take && ((st_q == F_PAY) ||
                      (!cfg_q.crc_data_only && (st_q == F_HDR || st_q == F_LEN)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= F_IDLE;
            cfg_q      <= '0;
            pre_left_q <= '0;
            idx_q      <= '0;
            pay_cnt_q  <= '0;
            sent_q     <= 1'b0;
        end else begin
            sent_q <= 1'b0;
            unique case (st_q)
                F_IDLE: begin
                    if (start) begin
                        cfg_q      <= cfg_in;
                        pre_left_q <= cfg_in.pre_nib;
                        idx_q      <= '0;
                        pay_cnt_q  <= '0;
                        if (!cfg_in.pkt_en)            st_q <= F_PAY;
                        else if (cfg_in.pre_nib != '0) st_q <= F_PRE;
                        else                           st_q <= F_SYNC;
                    end
                end
                F_DONE: begin
                    if (drain_done) begin
                        sent_q <= 1'b1;
                        st_q   <= F_IDLE;
                    end
                end
                default: begin
                    if (take) begin
                        unique case (st_q)
                            F_PRE: begin
                                if (pre_left_q <= PRE_NIB_W'(2)) begin
                                    pre_left_q <= '0;
                                    st_q       <= F_SYNC;
                                end else begin
                                    pre_left_q <= pre_left_q - PRE_NIB_W'(2);
                                end
                            end
                            F_SYNC: begin
                                if (idx_q == cfg_q.sync_last) begin
                                    idx_q <= '0;
                                    st_q  <= after_sync;
                                end else begin
                                    idx_q <= idx_q + SEL_W'(1);
                                end
                            end
                            F_HDR: begin
                                if (HCNT_W'(idx_q) == cfg_q.hdr_num - HCNT_W'(1)) begin
                                    idx_q <= '0;
                                    st_q  <= after_hdr;
                                end else begin
                                    idx_q <= idx_q + SEL_W'(1);
                                end
                            end
                            F_LEN: st_q <= F_PAY;
                            F_PAY: begin
                                if (pay_cnt_q == cfg_q.pay_len - LEN_W'(1)) st_q <= after_pay;
                                else pay_cnt_q <= pay_cnt_q + LEN_W'(1);
                            end
                            F_CRCH: st_q <= F_CRCL;
                            F_CRCL: st_q <= F_DONE;
                            default: st_q <= F_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    assign pkt_sent = sent_q;

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import ptf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_pkt_en,
    input  logic [7:0]  cfg_pre_len,
    input  logic        cfg_pre_msb,
    input  logic [1:0]  cfg_sync_cnt,
    input  logic [2:0]  cfg_hdr_cnt,
    input  logic        cfg_fix_len,
    input  logic        cfg_crc_en,
    input  logic        cfg_crc_data_only,
    input  logic        cfg_lsb_first,
    input  logic [31:0] cfg_sync_word,
    input  logic [31:0] cfg_hdr_word,
    input  logic [7:0]  cfg_pay_len,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        bit_stb,
    output logic        ser_bit,
    output logic        ser_active,
    output logic        pkt_sent
);

    cfg_t                cfg_in;
    logic                take;
    logic [BYTE_W-1:0]   nxt_data;
    logic [BITCNT_W-1:0] nxt_bits;
    logic                can_load;
    logic                drain_done;
    logic                crc_init;
    logic                crc_upd;
    logic [BYTE_W-1:0]   crc_byte;
    logic [CRC_W-1:0]    crc_val;

    always_comb begin
        cfg_in               = '0;
        cfg_in.pkt_en        = cfg_pkt_en;
        cfg_in.pre_nib       = {cfg_pre_msb, cfg_pre_len};
        cfg_in.sync_last     = cfg_sync_cnt;
        cfg_in.hdr_num       = clamp_hdr(cfg_hdr_cnt);
        cfg_in.fix_len       = cfg_fix_len;
        cfg_in.crc_en        = cfg_crc_en;
        cfg_in.crc_data_only = cfg_crc_data_only;
        cfg_in.lsb_first     = cfg_lsb_first;
        cfg_in.sync_w        = cfg_sync_word;
        cfg_in.hdr_w         = cfg_hdr_word;
        cfg_in.pay_len       = cfg_pay_len;
    end

    ptf_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_in     (cfg_in),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .can_load   (can_load),
        .drain_done (drain_done),
        .crc_val    (crc_val),
        .take       (take),
        .nxt_data   (nxt_data),
        .nxt_bits   (nxt_bits),
        .in_ready   (in_ready),
        .crc_init   (crc_init),
        .crc_upd    (crc_upd),
        .crc_byte   (crc_byte),
        .pkt_sent   (pkt_sent)
    );

    ptf_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .ld_data    (nxt_data),
        .ld_bits    (nxt_bits),
        .bit_stb    (bit_stb),
        .ser_bit    (ser_bit),
        .ser_active (ser_active),
        .can_load   (can_load),
        .drain_done (drain_done)
    );

    ptf_crc16 u_crc (
        .clk     (clk),
        .rst     (rst),
        .init    (crc_init),
        .upd     (crc_upd),
        .byte_in (crc_byte),
        .crc_out (crc_val)
    );

endmodule

// File: rtl/ptf_checker.sv
module ptf_checker (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic bit_stb,
    input logic ser_bit,
    input logic ser_active,
    input logic pkt_sent
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ser_active && !pkt_sent && !in_ready)); // R1

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) in_ready |-> in_valid); // R6

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (ser_active && !bit_stb) |=> (ser_active && $stable(ser_bit))); // R10

    AST_SENT_SINGLE: assert property (@(posedge clk) disable iff (rst) pkt_sent |=> !pkt_sent); // R11

    AST_SENT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        pkt_sent |-> $past(ser_active && bit_stb)); // R11

    AST_SENT_LINE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        pkt_sent |-> (!ser_active && !in_ready)); // R11

endmodule

bind pkt_tx_framer ptf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .bit_stb    (bit_stb),
    .ser_bit    (ser_bit),
    .ser_active (ser_active),
    .pkt_sent   (pkt_sent)
);

// File: tb/sim_pkt_tx_framer.sv
`timescale 1ns/1ps
module sim_pkt_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int PKT_LIMIT  = 6000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_pkt_en, cfg_pre_msb, cfg_fix_len, cfg_crc_en, cfg_crc_data_only, cfg_lsb_first;
    logic [7:0]  cfg_pre_len, cfg_pay_len, in_data;
    logic [1:0]  cfg_sync_cnt;
    logic [2:0]  cfg_hdr_cnt;
    logic [31:0] cfg_sync_word, cfg_hdr_word;
    logic        in_valid, in_ready, bit_stb, ser_bit, ser_active, pkt_sent;

    int checks = 0;
    int errors = 0;
    logic [7:0] pay [0:255];
    bit exp_q[$];
    bit got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_tx_framer u0 (
        .clk(clk), .rst(rst), .cfg_pkt_en(cfg_pkt_en), .cfg_pre_len(cfg_pre_len),
        .cfg_pre_msb(cfg_pre_msb), .cfg_sync_cnt(cfg_sync_cnt), .cfg_hdr_cnt(cfg_hdr_cnt),
        .cfg_fix_len(cfg_fix_len), .cfg_crc_en(cfg_crc_en), .cfg_crc_data_only(cfg_crc_data_only),
        .cfg_lsb_first(cfg_lsb_first), .cfg_sync_word(cfg_sync_word), .cfg_hdr_word(cfg_hdr_word),
        .cfg_pay_len(cfg_pay_len), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .bit_stb(bit_stb), .ser_bit(ser_bit), .ser_active(ser_active), .pkt_sent(pkt_sent)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic push_byte(input logic [7:0] b, input bit lsb);
        for (int i = 0; i < 8; i++) exp_q.push_back(lsb ? b[i] : b[7-i]);
    endtask

    task automatic build_expected();
        logic [15:0] c;
        int nib, hn;
        exp_q.delete();
        c = 16'hFFFF;
        if (!cfg_pkt_en) begin
            for (int i = 0; i < cfg_pay_len; i++) push_byte(pay[i], cfg_lsb_first);
            return;
        end
        nib = {cfg_pre_msb, cfg_pre_len};
        for (int k = 0; k < nib*4; k++) exp_q.push_back((k % 2) == 0);
        for (int j = 0; j <= cfg_sync_cnt; j++) push_byte(cfg_sync_word[8*(3-j) +: 8], cfg_lsb_first);
        hn = (cfg_hdr_cnt > 4) ? 4 : cfg_hdr_cnt;
        for (int j = 0; j < hn; j++) begin
            push_byte(cfg_hdr_word[8*(3-j) +: 8], cfg_lsb_first);
            if (!cfg_crc_data_only) c = ref_crc(c, cfg_hdr_word[8*(3-j) +: 8]);
        end
        if (!cfg_fix_len) begin
            push_byte(cfg_pay_len, cfg_lsb_first);
            if (!cfg_crc_data_only) c = ref_crc(c, cfg_pay_len);
        end
        for (int i = 0; i < cfg_pay_len; i++) begin
            push_byte(pay[i], cfg_lsb_first);
            c = ref_crc(c, pay[i]);
        end
        if (cfg_crc_en) begin
            push_byte(c[15:8], cfg_lsb_first);
            push_byte(c[7:0], cfg_lsb_first);
        end
    endtask

    task automatic run_pkt(input string req, input int stb_pct, input int vld_pct, input bit mid_change);
        int pidx = 0, iter = 0, sent_iter = -1, sent_cnt = 0, last_iter = -2;
        int ready_bad = 0, hold_bad = 0, mis = -1, len;
        bit prev_hold = 0, prev_bit = 0, timeout = 0, changed = 0;
        for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
        build_expected();
        len = cfg_pay_len;
        got_q.delete();
        while (1) begin
            @(negedge clk);
            in_valid = (pidx < len) && ($urandom_range(99) < vld_pct);
            in_data  = pay[pidx];
            bit_stb  = ($urandom_range(99) < stb_pct);
            #1;
            if (prev_hold && !(ser_active && ser_bit == prev_bit)) hold_bad++;
            prev_hold = ser_active && !bit_stb;
            prev_bit  = ser_bit;
            if (in_ready && !in_valid) ready_bad++;
            if (in_ready && in_valid) pidx++;
            if (ser_active && bit_stb) begin
                got_q.push_back(ser_bit);
                last_iter = iter;
            end
            if (pkt_sent) begin
                sent_cnt++;
                if (sent_iter < 0) sent_iter = iter;
            end
            if (mid_change && !changed && got_q.size() == 3) begin
                changed = 1;
                cfg_sync_cnt  = cfg_sync_cnt + 2'd1;
                cfg_lsb_first = ~cfg_lsb_first;
                cfg_fix_len   = ~cfg_fix_len;
                cfg_hdr_word  = ~cfg_hdr_word;
            end
            iter++;
            if (sent_iter >= 0 && iter > sent_iter + 4) break;
            if (iter > PKT_LIMIT) begin timeout = 1; break; end
        end
        @(negedge clk);
        in_valid = 1'b0;
        bit_stb  = 1'b0;
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (mis < 0 && got_q[i] != exp_q[i]) mis = i;
        chk(!timeout, req, "packet watchdog", iter, PKT_LIMIT);
        chk(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
        chk(mis < 0, req, "first mismatched bit index", mis, -1);
        chk(sent_cnt == 1, "R11", "pkt_sent pulse count", sent_cnt, 1);
        chk(sent_iter == last_iter + 1, "R11", "pkt_sent cycle", sent_iter, last_iter + 1);
        chk(ready_bad == 0, "R6", "in_ready without in_valid", ready_bad, 0);
        chk(pidx == len, "R6", "payload bytes taken", pidx, len);
        chk(hold_bad == 0, "R10", "bit changed without strobe", hold_bad, 0);
    endtask

    task automatic set_cfg(input bit en, input int pre, input int sc, input int hc, input bit fix,
                           input bit crc, input bit donly, input bit lsb, input int len);
        cfg_pkt_en = en; {cfg_pre_msb, cfg_pre_len} = 9'(pre); cfg_sync_cnt = 2'(sc);
        cfg_hdr_cnt = 3'(hc); cfg_fix_len = fix; cfg_crc_en = crc; cfg_crc_data_only = donly;
        cfg_lsb_first = lsb; cfg_pay_len = 8'(len);
        cfg_sync_word = $urandom; cfg_hdr_word = $urandom;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; errors++;
        $display("FAIL global watchdog R11 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'h5EED_0017));
        rst = 1'b1; in_valid = 1'b1; in_data = 8'h00; bit_stb = 1'b1;
        set_cfg(1, 8, 1, 2, 0, 1, 0, 0, 4);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            if (ser_active || in_ready || pkt_sent) bad++;
        end
        rst = 1'b0;
        @(negedge clk); #1;
        if (ser_active || pkt_sent) bad++;
        chk(bad == 0, "R1", "outputs quiet in reset", bad, 0);
        in_valid = 1'b0; bit_stb = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);

        set_cfg(1, 8, 1, 2, 0, 1, 0, 0, 5);  run_pkt("R2/R3/R4/R5/R7 default frame", 60, 70, 0);
        set_cfg(1, 5, 3, 0, 1, 0, 0, 0, 3);  run_pkt("R2/R3/R5/R7 odd preamble, no header, fixed, no CRC", 50, 80, 0);
        set_cfg(1, 2, 0, 4, 0, 1, 1, 1, 6);  run_pkt("R4/R7/R8 data-only CRC, LSB first", 70, 60, 0);
        set_cfg(0, 9, 2, 3, 0, 1, 0, 1, 7);  run_pkt("R9/R8 raw mode", 60, 60, 0);
        set_cfg(1, 256, 0, 1, 1, 1, 0, 0, 2); run_pkt("R2 ninth preamble bit", 100, 100, 0);
        set_cfg(1, 0, 1, 7, 0, 1, 0, 0, 3);  run_pkt("R4 header code clamped, R2 no preamble", 55, 65, 0);
        set_cfg(1, 4, 1, 2, 0, 1, 0, 0, 9);  run_pkt("R12 config change mid packet", 50, 70, 1);
        set_cfg(1, 3, 2, 2, 0, 1, 0, 1, 12); run_pkt("R6/R10 back-to-back handoff", 100, 100, 0);

        set_cfg(1, 4, 0, 0, 0, 1, 0, 0, 0);
        in_valid = 1'b1; bit_stb = 1'b1; bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (ser_active || in_ready || pkt_sent) bad++;
        end
        in_valid = 1'b0; bit_stb = 1'b0;
        chk(bad == 0, "R6", "zero length starts nothing", bad, 0);

        for (int n = 0; n < 20; n++) begin
            set_cfg($urandom_range(9) != 0, $urandom_range(0, 20), $urandom_range(0, 3),
                    $urandom_range(0, 7), $urandom_range(1), $urandom_range(1),
                    $urandom_range(1), $urandom_range(1), $urandom_range(1, 24));
            run_pkt("R2/R3/R4/R5/R7/R8/R9 random", $urandom_range(30, 100), $urandom_range(40, 100), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule